// File: doc/BRIEF.md
# Register stack push/pull sequencer

This block saves or restores any subset of a small processor register file to or from a byte-wide memory in one operation. An 8-bit select mask names the registers to move. The block walks through the chosen registers in one fixed order and moves one byte per cycle over a simple memory strobe interface. The mask can be any value.

A stack select input picks the active pointer: the system pointer or the user pointer. The inactive pointer is treated as an ordinary register that can be saved or restored. A save, or push, lowers the active pointer before each byte it writes. A restore, or pull, reads each byte and then raises the pointer. Every operation costs a fixed setup overhead plus one cycle per byte. A single-cycle completion pulse marks the end of the operation.

The host drives a start request with the direction, the stack select and the mask, then waits for the completion pulse. The memory read path is combinational: read data must be valid in the same cycle as the read strobe.

Top module: `stk_push_pull`

## Requirements
- R1: Each mask bit selects one register: bit 7 = PC, bit 6 = the inactive stack pointer, bit 5 = Y, bit 4 = X, bit 3 = DP, bit 2 = B, bit 1 = A, bit 0 = CC. Exactly one memory access is made per byte of each selected register (two for PC, X, Y and the pointer, one for the others), and none for unselected ones.
- R2: A push writes in this order: PC low, PC high, pointer low, pointer high, Y low, Y high, X low, X high, DP, B, A, CC. Unselected registers are skipped, and the order of the rest does not change.
- R3: Before each byte write, the active pointer is lowered by one. The write goes to the lowered address. After a push of N bytes the pointer has dropped by N.
- R4: A pull reads in the reverse order of R2, starting at the active pointer. It raises the pointer by one after each read. The high byte of a 16-bit register is at the lower address.
- R5: On the system stack the pointer slot holds the user pointer. On the user stack it holds the system pointer, in both directions.
- R6: From the cycle after start is accepted, busy stays high for 5 + N cycles. The done output is high only in the last of those cycles.
- R7: A mask of zero still takes 5 busy cycles and makes no memory access.
- R8: A start request is ignored while busy. It does not change the direction, stack, mask or length of the running operation.
- R9: After reset, the system and user pointers hold their parameter reset values, all other registers are zero, and busy and done are low.
- R10: Write and read strobes are never high together, and both are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| push_i | input | 1 | 1 = push (save), 0 = pull (restore) |
| user_stack_i | input | 1 | 1 = use the user pointer, 0 = the system pointer |
| sel_mask_i | input | 8 | Register select mask (R1) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse, last busy cycle |
| mem_addr_o | output | 16 | Byte address |
| mem_we_o | output | 1 | Byte write strobe |
| mem_re_o | output | 1 | Byte read strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the read cycle |
| sys_sp_o | output | 16 | System stack pointer |
| usr_sp_o | output | 16 | User stack pointer |

## Verification
The assertions check several rules on every cycle:
- the pre-decrement addressing and one-step pointer movement for writes, and read-then-increment for reads;
- the strobe exclusivity and quiet idle;
- the single-cycle done pulse;
- that the busy length and the access count match the latched mask.

Only the bench scenarios can show the byte order, the swap of the pointer slot between stacks, that restored values come back out unchanged on a later push, and that a start raised mid-operation is ignored. The bench sweeps every mask value in both directions on both stacks and compares each operation against a byte-level model.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MASK_W  = 8;
  localparam int unsigned SLOT_N  = 12;
  localparam int unsigned SLOT_IW = $clog2(SLOT_N);
  localparam int unsigned PRE_CYC = 4;   // base cost minus the done cycle
  localparam int unsigned WIDE_LO = 4;   // first mask bit naming a 16-bit register
  localparam int unsigned OTH_HI  = 8;   // slot of the inactive pointer high byte
  localparam int unsigned OTH_LO  = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_XFER, ST_FIN} stk_state_e;

  // slot order is pull order: CC A B DP Xh Xl Yh Yl Ph Pl PCh PCl
  function automatic logic [SLOT_N-1:0] expand_mask(input logic [MASK_W-1:0] m);
    logic [SLOT_N-1:0] s;
    s = '0;
    for (int i = 0; i < int'(WIDE_LO); i++) s[i] = m[i];
    for (int j = 0; j < int'(MASK_W - WIDE_LO); j++) begin
      s[WIDE_LO + 2*j]     = m[WIDE_LO + j];
      s[WIDE_LO + 2*j + 1] = m[WIDE_LO + j];
    end
    return s;
  endfunction
endpackage

// File: rtl/stk_slot_pick.sv
module stk_slot_pick #(
  parameter int unsigned N  = 12,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic          hi_first_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  rest_o
);
  logic [IW-1:0] idx_lo, idx_hi;

  always_comb begin
    idx_lo = '0;
    idx_hi = '0;
    for (int i = N - 1; i >= 0; i--) if (pend_i[i]) idx_lo = IW'(i);
    for (int i = 0; i < N; i++)      if (pend_i[i]) idx_hi = IW'(i);
  end

  assign idx_o  = hi_first_i ? idx_hi : idx_lo;
  assign rest_o = pend_i & ~(N'(1) << idx_o);
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile import stk_pkg::*; #(
  parameter logic [WORD_W-1:0] SYS_RST = 16'h00C0,
  parameter logic [WORD_W-1:0] USR_RST = 16'h0060
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               user_i,
  input  logic               wr_en_i,
  input  logic [SLOT_IW-1:0] idx_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0]  rdata_o,
  input  logic               step_en_i,
  input  logic               step_down_i,
  output logic [WORD_W-1:0]  act_sp_o,
  output logic [WORD_W-1:0]  sys_sp_o,
  output logic [WORD_W-1:0]  usr_sp_o
);
  logic [BYTE_W-1:0] gp_q [SLOT_N];
  logic [WORD_W-1:0] sys_q, usr_q, sys_d, usr_d, oth;
  logic              oth_hit, gp_hit;

  assign oth     = user_i ? sys_q : usr_q;
  assign oth_hit = (idx_i == SLOT_IW'(OTH_HI)) || (idx_i == SLOT_IW'(OTH_LO));
  assign gp_hit  = !oth_hit && (idx_i < SLOT_IW'(SLOT_N));

  always_comb begin
    sys_d = sys_q;
    usr_d = usr_q;
    if (step_en_i) begin
      if (user_i) usr_d = step_down_i ? usr_q - 1'b1 : usr_q + 1'b1;
      else        sys_d = step_down_i ? sys_q - 1'b1 : sys_q + 1'b1;
    end
    if (wr_en_i && oth_hit) begin
      if (idx_i == SLOT_IW'(OTH_HI)) begin
        if (user_i) sys_d[WORD_W-1:BYTE_W] = wdata_i;
        else        usr_d[WORD_W-1:BYTE_W] = wdata_i;
      end else begin
        if (user_i) sys_d[BYTE_W-1:0] = wdata_i;
        else        usr_d[BYTE_W-1:0] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= SYS_RST;
      usr_q <= USR_RST;
      for (int i = 0; i < int'(SLOT_N); i++) gp_q[i] <= '0;
    end else begin
      sys_q <= sys_d;
      usr_q <= usr_d;
      if (wr_en_i && gp_hit) gp_q[idx_i] <= wdata_i;
    end
  end

  always_comb begin
    if (idx_i == SLOT_IW'(OTH_HI))      rdata_o = oth[WORD_W-1:BYTE_W];
    else if (idx_i == SLOT_IW'(OTH_LO)) rdata_o = oth[BYTE_W-1:0];
    else if (gp_hit)                    rdata_o = gp_q[idx_i];
    else                                rdata_o = '0;
  end

  assign act_sp_o = user_i ? usr_q : sys_q;
  assign sys_sp_o = sys_q;
  assign usr_sp_o = usr_q;
endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl import stk_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               push_i,
  input  logic               user_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               xfer_o,
  output logic               push_q_o,
  output logic               user_q_o,
  output logic [SLOT_IW-1:0] slot_o
);
  localparam int unsigned CW = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;

  stk_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [SLOT_N-1:0] pend_q, rest;
  logic              push_q, user_q;

  stk_slot_pick #(.N(SLOT_N), .IW(SLOT_IW)) u_pick (
    .pend_i    (pend_q),
    .hi_first_i(push_q),
    .idx_o     (slot_o),
    .rest_o    (rest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= '0;
      push_q  <= 1'b0;
      user_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pend_q  <= expand_mask(mask_i);
          push_q  <= push_i;
          user_q  <= user_i;
          cnt_q   <= '0;
          state_q <= ST_PRE;
        end
        ST_PRE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(PRE_CYC - 1)) state_q <= (|pend_q) ? ST_XFER : ST_FIN;
        end
        ST_XFER: begin
          pend_q <= rest;
          if (rest == '0) state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);
  assign xfer_o   = (state_q == ST_XFER);
  assign push_q_o = push_q;
  assign user_q_o = user_q;
endmodule

// File: rtl/stk_push_pull.sv
module stk_push_pull import stk_pkg::*; #(
  parameter logic [WORD_W-1:0] SYS_SP_RST = 16'h00C0,
  parameter logic [WORD_W-1:0] USR_SP_RST = 16'h0060
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              push_i,
  input  logic              user_stack_i,
  input  logic [MASK_W-1:0] sel_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] sys_sp_o,
  output logic [WORD_W-1:0] usr_sp_o
);
  logic               xfer, push_q, user_q;
  logic [SLOT_IW-1:0] slot;
  logic [WORD_W-1:0]  act_sp;

  stk_seq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .push_i  (push_i),
    .user_i  (user_stack_i),
    .mask_i  (sel_mask_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .xfer_o  (xfer),
    .push_q_o(push_q),
    .user_q_o(user_q),
    .slot_o  (slot)
  );

  stk_regfile #(.SYS_RST(SYS_SP_RST), .USR_RST(USR_SP_RST)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .user_i     (user_q),
    .wr_en_i    (xfer && !push_q),
    .idx_i      (slot),
    .wdata_i    (mem_rdata_i),
    .rdata_o    (mem_wdata_o),
    .step_en_i  (xfer),
    .step_down_i(push_q),
    .act_sp_o   (act_sp),
    .sys_sp_o   (sys_sp_o),
    .usr_sp_o   (usr_sp_o)
  );

  // push writes below the pointer, pull reads at it
  assign mem_addr_o = push_q ? act_sp - 1'b1 : act_sp;
  assign mem_we_o   = xfer && push_q;
  assign mem_re_o   = xfer && !push_q;
endmodule

// File: rtl/stk_push_pull_chk.sv
module stk_push_pull_chk import stk_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MASK_W-1:0] sel_mask_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] sys_sp_o,
  input logic [WORD_W-1:0] usr_sp_o,
  input logic              user_q_i
);
  logic [4:0]        nbytes_q, cyc_q, acc_q;
  logic [WORD_W-1:0] act_sp;

  assign act_sp = user_q_i ? usr_sp_o : sys_sp_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nbytes_q <= '0;
      cyc_q    <= '0;
      acc_q    <= '0;
    end else if (start_i && !busy_o) begin
      nbytes_q <= 5'($countones(expand_mask(sel_mask_i)));
      cyc_q    <= '0;
      acc_q    <= '0;
    end else begin
      if (busy_o) cyc_q <= cyc_q + 1'b1;
      if (mem_we_o || mem_re_o) acc_q <= acc_q + 1'b1;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o && !mem_re_o);
  assert_push_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == act_sp - 16'd1);
  assert_push_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> act_sp == $past(act_sp) - 16'd1);
  assert_pull_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> mem_addr_o == act_sp);
  assert_pull_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> act_sp == $past(act_sp) + 16'd1);
  assert_cycle_cost_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cyc_q == nbytes_q + 5'd4);
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_access_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> acc_q == nbytes_q);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(sys_sp_o) && $stable(usr_sp_o));
endmodule

bind stk_push_pull stk_push_pull_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .sel_mask_i(sel_mask_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .mem_addr_o(mem_addr_o),
  .sys_sp_o  (sys_sp_o),
  .usr_sp_o  (usr_sp_o),
  .user_q_i  (user_q)
);

// File: tb/stk_push_pull_tb_top.sv
module stk_push_pull_tb_top;
  localparam logic [15:0] SYS0 = 16'h00C0;
  localparam logic [15:0] USR0 = 16'h0060;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, push = 1'b0, user = 1'b0;
  logic [7:0]  mask = '0;
  logic        busy, done, mem_we, mem_re;
  logic [15:0] mem_addr, sys_sp, usr_sp;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [256];

  always #2 clk = ~clk;

  stk_push_pull #(.SYS_SP_RST(SYS0), .USR_SP_RST(USR0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .push_i(push),
    .user_stack_i(user), .sel_mask_i(mask), .busy_o(busy), .done_o(done),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .sys_sp_o(sys_sp), .usr_sp_o(usr_sp)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [7:0]  m_gp [12];
  logic [15:0] m_sys, m_usr;
  logic [15:0] w_addr [16];
  logic [7:0]  w_dat [16];
  int nw, nr, ncyc, ndone;
  bit done_last, strobe_idle;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit msel(input int i, input logic [7:0] m);
    return (i < 4) ? m[i] : m[4 + (i - 4) / 2];
  endfunction

  function automatic int nbytes(input logic [7:0] m);
    int n = 0;
    for (int i = 0; i < 12; i++) if (msel(i, m)) n++;
    return n;
  endfunction

  task automatic run_op(input bit p, input bit u, input logic [7:0] m, input bit poke);
    @(negedge clk);
    start = 1'b1; push = p; user = u; mask = m;
    @(negedge clk);
    start = 1'b0;
    nw = 0; nr = 0; ncyc = 0; ndone = 0; done_last = 1'b0;
    while (busy && ncyc < 40) begin
      ncyc++;
      if (mem_we) begin
        if (nw < 16) begin w_addr[nw] = mem_addr; w_dat[nw] = mem_wdata; end
        nw++;
      end
      if (mem_re) nr++;
      done_last = done;
      if (done) ndone++;
      if (poke && ncyc == 3) begin start = 1'b1; push = !p; user = !u; mask = ~m; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    strobe_idle = !mem_we && !mem_re;
  endtask

  task automatic common_checks(input logic [7:0] m, input string tag);
    int n = nbytes(m);
    chk(ncyc == 5 + n, "R6", {tag, " busy cycles"}, ncyc, 5 + n);
    chk(ndone == 1 && done_last, "R6", {tag, " done in last cycle"}, ndone, 1);
    chk(strobe_idle, "R10", {tag, " strobes idle"}, {mem_we, mem_re}, 0);
    chk(sys_sp == m_sys, "R3", {tag, " system pointer"}, sys_sp, m_sys);
    chk(usr_sp == m_usr, "R4", {tag, " user pointer"}, usr_sp, m_usr);
  endtask

  task automatic do_push(input bit u, input logic [7:0] m, input bit poke);
    logic [15:0] sp, oth;
    int k = 0;
    run_op(1'b1, u, m, poke);
    sp  = u ? m_usr : m_sys;
    oth = u ? m_sys : m_usr;
    for (int i = 11; i >= 0; i--) begin
      if (msel(i, m)) begin
        logic [7:0] b;
        sp = sp - 16'd1;
        b = (i == 8) ? oth[15:8] : (i == 9) ? oth[7:0] : m_gp[i];
        if (k < 16) begin
          chk(w_addr[k] == sp, "R3", "push address", w_addr[k], sp);
          chk(w_dat[k] == b, (i == 8 || i == 9) ? "R5" : "R2", "push byte", w_dat[k], b);
        end
        k++;
      end
    end
    chk(nw == k, "R1", "push write count", nw, k);
    chk(nr == 0, "R1", "push read count", nr, 0);
    if (u) m_usr = sp; else m_sys = sp;
    common_checks(m, poke ? "R8 push" : "push");
  endtask

  task automatic do_pull(input bit u, input logic [7:0] m);
    logic [15:0] sp;
    int k = 0;
    sp = u ? m_usr : m_sys;
    for (int i = 0; i < 12; i++) begin
      if (msel(i, m)) begin
        logic [7:0] b = mem[sp[7:0]];
        if (i == 8)      begin if (u) m_sys[15:8] = b; else m_usr[15:8] = b; end
        else if (i == 9) begin if (u) m_sys[7:0] = b;  else m_usr[7:0] = b;  end
        else m_gp[i] = b;
        sp = sp + 16'd1;
        k++;
      end
    end
    if (u) m_usr = sp; else m_sys = sp;
    run_op(1'b0, u, m, 1'b0);
    chk(nr == k, "R4", "pull read count", nr, k);
    chk(nw == 0, "R1", "pull write count", nw, 0);
    common_checks(m, "pull");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    for (int i = 0; i < 12; i++) m_gp[i] = '0;
    m_sys = SYS0;
    m_usr = USR0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R9", "reset busy/done", {busy, done}, 0);
    chk(sys_sp == SYS0, "R9", "reset system pointer", sys_sp, SYS0);
    chk(usr_sp == USR0, "R9", "reset user pointer", usr_sp, USR0);
    rst_n = 1'b1;

    // R9: registers read back as zero after reset
    do_push(1'b0, 8'hFF, 1'b0);
    // R7: empty mask in both directions
    do_push(1'b1, 8'h00, 1'b0);
    chk(nw == 0 && ncyc == 5, "R7", "empty push", ncyc, 5);
    do_pull(1'b0, 8'h00);
    chk(nr == 0 && ncyc == 5, "R7", "empty pull", ncyc, 5);

    for (int it = 0; it < 256; it++) begin
      @(negedge clk);
      for (int a = 0; a < 256; a++) mem[a] = 8'(a * 13 + it * 7 + 1);
      do_pull(it[1], 8'(it));
      do_push(it[2], 8'(it) ^ 8'h5A, (it % 16) == 5);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule